// File: doc/BRIEF.md
# Bit Scan and Count Unit

This unit takes a 16-bit source word and an operation code. It can return the position of the lowest set bit or the highest set bit. It can also return the number of ones, the number of zeros below the lowest one, or the number of zeros above the highest one. Each result comes with a destination write-enable and six arithmetic status flags. Each flag has its own update bit, so the consuming pipeline knows which flags it should commit.

The unit is one registered stage. A request is sampled at a clock edge where `valid_i` is high. At the next edge the result appears together with a one-cycle `done_o` pulse. A new request can be accepted in every cycle. The two scan operations on a zero source do not write the destination. The other operations always write it. Each operation has its own flag rule.

Top module: `bitscan_unit`

## Requirements
- R1: A request presented with `valid_i` high at a rising edge produces `done_o` high for exactly one cycle after that edge, with the result fields of that request. `done_o` is low after every edge that had `valid_i` low, including all edges during and just after reset. Back-to-back requests are each answered in order.
- R2: With op code 0 (forward scan) and a non-zero source, `result_o` is the index (0 to 15) of the least significant one bit, and `wr_en_o` is 1.
- R3: With op code 1 (reverse scan) and a non-zero source, `result_o` is the index of the most significant one bit, and `wr_en_o` is 1.
- R4: The flags use the bit order CF=bit 0, PF=bit 1, AF=bit 2, ZF=bit 3, SF=bit 4, OF=bit 5. For a scan with a non-zero source, CF, AF, ZF and OF are 0. SF equals bit 15 of the result. PF is 1 when bits 7:0 of the result hold an even number of ones. All six update bits are 1.
- R5: For op code 0 or 1 with a zero source, `wr_en_o` is 0, ZF is 1, all other flag bits are 0, and the only update bit set is ZF (mask 6'b001000).
- R6: With op code 2 (population count), `result_o` is the number of one bits in the source and `wr_en_o` is 1. ZF is 1 exactly when the source is zero, the other five flags are 0, and all six update bits are 1.
- R7: With op code 3 (trailing-zero count), `result_o` is the number of zero bits below the lowest one bit, or 16 for a zero source. `wr_en_o` is 1.
- R8: With op code 4 (leading-zero count), `result_o` is the number of zero bits above the highest one bit, or 16 for a zero source. `wr_en_o` is 1.
- R9: For op codes 3 and 4, CF is 1 exactly when the source is zero and ZF is 1 exactly when the result is zero. The other flag bits are 0. Only the CF and ZF update bits are set (mask 6'b001001).
- R10: Op codes 5, 6 and 7 give a `done_o` pulse with `wr_en_o` 0 and all update bits 0.
- R11: While `done_o` is low, `wr_en_o` and every bit of `flag_upd_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (0..4 used) |
| src_i | input | 16 | Source operand |
| done_o | output | 1 | Result valid pulse |
| result_o | output | 16 | Result value |
| wr_en_o | output | 1 | Destination write-enable |
| flags_o | output | 6 | Flag values {OF,SF,ZF,AF,PF,CF} |
| flag_upd_o | output | 6 | Per-flag commit mask, same bit order |

## Verification
Two things can occur in the same cycle. One is the presentation of one request's result. The other is the capture of the next request, which may use a different operation or a different zero/non-zero case. The bench provokes this with long runs of back-to-back strobes that alternate operations, zero sources and unused codes. A queue-based scoreboard then compares every `done_o` pulse with an expectation computed from the requirements, so a result, write-enable or mask that leaks from one request into the next is reported. Trailing- and leading-zero counts also have inputs that set ZF and CF on their own (result zero, source zero), and both cases are checked.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [2:0] {
    OP_FWD = 3'd0,
    OP_REV = 3'd1,
    OP_POP = 3'd2,
    OP_TZC = 3'd3,
    OP_LZC = 3'd4
  } op_e;

  localparam int FLG_N  = 6;
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_AF = 2;
  localparam int FLG_ZF = 3;
  localparam int FLG_SF = 4;
  localparam int FLG_OF = 5;

  localparam logic [FLG_N-1:0] UPD_ALL   = 6'b111111;
  localparam logic [FLG_N-1:0] UPD_ZONLY = 6'b001000;
  localparam logic [FLG_N-1:0] UPD_CZ    = 6'b001001;

  function automatic logic even_par8(input logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/bsc_scan.sv
module bsc_scan #(
  parameter int DATA_W   = 16,
  parameter bit FROM_MSB = 1'b0,
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] vec_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              found_o
);

  assign found_o = |vec_i;

  generate
    if (FROM_MSB) begin : g_high
      // ascending walk: the highest set bit is written last
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
          if (vec_i[i]) idx_o = IDX_W'(i);
        end
      end
    end else begin : g_low
      // descending walk: the lowest set bit is written last
      always_comb begin
        idx_o = '0;
        for (int i = DATA_W-1; i >= 0; i--) begin
          if (vec_i[i]) idx_o = IDX_W'(i);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bsc_popcnt.sv
module bsc_popcnt #(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] vec_i,
  output logic [CNT_W-1:0]  cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < DATA_W; i++) begin
      cnt_o = cnt_o + CNT_W'(vec_i[i]);
    end
  end

endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit
  import bsc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [5:0]        flags_o,
  output logic [5:0]        flag_upd_o
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam int CNT_W = IDX_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [IDX_W-1:0] lo_idx, hi_idx;
  logic             lo_found, hi_found;
  logic [CNT_W-1:0] pop_cnt;

  bsc_scan #(.DATA_W(DATA_W), .FROM_MSB(1'b0)) u_scan_lo (
    .vec_i  (src_i),
    .idx_o  (lo_idx),
    .found_o(lo_found)
  );

  bsc_scan #(.DATA_W(DATA_W), .FROM_MSB(1'b1)) u_scan_hi (
    .vec_i  (src_i),
    .idx_o  (hi_idx),
    .found_o(hi_found)
  );

  bsc_popcnt #(.DATA_W(DATA_W)) u_pop (
    .vec_i(src_i),
    .cnt_o(pop_cnt)
  );

  // next-state computation
  logic [DATA_W-1:0] res_d;
  logic              wr_d;
  logic [FLG_N-1:0]  flg_d, upd_d;

  always_comb begin
    res_d = '0;
    wr_d  = 1'b0;
    flg_d = '0;
    upd_d = '0;
    case (op_i)
      OP_FWD, OP_REV: begin
        if (lo_found) begin
          res_d = (op_i == OP_FWD) ? DATA_W'(lo_idx) : DATA_W'(hi_idx);
          wr_d  = 1'b1;
          flg_d[FLG_SF] = res_d[DATA_W-1];
          flg_d[FLG_PF] = even_par8(res_d[7:0]);
          upd_d = UPD_ALL;
        end else begin
          flg_d[FLG_ZF] = 1'b1;
          upd_d = UPD_ZONLY;
        end
      end
      OP_POP: begin
        res_d = DATA_W'(pop_cnt);
        wr_d  = 1'b1;
        flg_d[FLG_ZF] = ~lo_found;
        upd_d = UPD_ALL;
      end
      OP_TZC: begin
        res_d = lo_found ? DATA_W'(lo_idx) : DATA_W'(DATA_W);
        wr_d  = 1'b1;
        flg_d[FLG_CF] = ~lo_found;
        flg_d[FLG_ZF] = lo_found & (lo_idx == '0);
        upd_d = UPD_CZ;
      end
      OP_LZC: begin
        res_d = hi_found ? DATA_W'(IDX_W'(DATA_W-1) - hi_idx) : DATA_W'(DATA_W);
        wr_d  = 1'b1;
        flg_d[FLG_CF] = ~hi_found;
        flg_d[FLG_ZF] = hi_found & (hi_idx == IDX_W'(DATA_W-1));
        upd_d = UPD_CZ;
      end
      default: begin
        res_d = '0;
      end
    endcase
  end

  // registers
  logic              done_q;
  logic [DATA_W-1:0] res_q;
  logic              wr_q;
  logic [FLG_N-1:0]  flg_q, upd_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= valid_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      wr_q  <= 1'b0;
      flg_q <= '0;
      upd_q <= '0;
    end else if (valid_i) begin
      res_q <= res_d;
      wr_q  <= wr_d;
      flg_q <= flg_d;
      upd_q <= upd_d;
    end
  end

  assign done_o     = done_q;
  assign result_o   = res_q;
  assign wr_en_o    = done_q & wr_q;
  assign flags_o    = flg_q;
  assign flag_upd_o = done_q ? upd_q : '0;

endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] src_i,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [5:0]        flags_o,
  input logic [5:0]        flag_upd_o
);

  localparam int IDX_W = $clog2(DATA_W);

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o); // R1

  AST_NO_DONE_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !done_o); // R1

  AST_FWD_HITS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd0 && src_i != '0) |=>
      (($past(src_i) >> result_o[IDX_W-1:0]) & DATA_W'(1)) == DATA_W'(1)); // R2

  AST_REV_HITS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd1 && src_i != '0) |=>
      (($past(src_i) >> result_o[IDX_W-1:0]) & DATA_W'(1)) == DATA_W'(1)); // R3

  AST_SCAN_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i <= 3'd1 && src_i == '0) |=>
      (!wr_en_o && flags_o[3] && flag_upd_o == 6'b001000)); // R5

  AST_POP_ZF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd2) |=> (flags_o[3] == (result_o == '0))); // R6

  AST_CNT_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 3'd3 || op_i == 3'd4) && src_i == '0) |=>
      (result_o == DATA_W'(DATA_W) && flags_o[0] && wr_en_o)); // R9

  AST_BAD_OP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i > 3'd4) |=> (!wr_en_o && flag_upd_o == '0)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (!wr_en_o && flag_upd_o == '0)); // R11

endmodule

bind bitscan_unit bsc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .src_i     (src_i),
  .done_o    (done_o),
  .result_o  (result_o),
  .wr_en_o   (wr_en_o),
  .flags_o   (flags_o),
  .flag_upd_o(flag_upd_o)
);

// File: tb/bitscan_unit_test.sv
module bitscan_unit_test;

  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [2:0]  op_i;
  logic [15:0] src_i;
  logic        done_o;
  logic [15:0] result_o;
  logic        wr_en_o;
  logic [5:0]  flags_o;
  logic [5:0]  flag_upd_o;

  bitscan_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .src_i(src_i),
    .done_o(done_o), .result_o(result_o), .wr_en_o(wr_en_o),
    .flags_o(flags_o), .flag_upd_o(flag_upd_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [15:0] res;
    logic        wr;
    logic [5:0]  flg;
    logic [5:0]  upd;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   finished = 0;

  function automatic exp_t model(input logic [2:0] op, input logic [15:0] s);
    exp_t e;
    int lo, hi, ones;
    lo = -1; hi = -1; ones = 0;
    for (int i = 0; i < 16; i++) begin
      if (s[i]) begin
        if (lo < 0) lo = i;
        hi = i;
        ones++;
      end
    end
    e.res = 16'd0; e.wr = 1'b0; e.flg = 6'd0; e.upd = 6'd0; e.tag = "R10";
    case (op)
      3'd0, 3'd1: begin
        if (s == 16'd0) begin
          e.flg = 6'b001000; e.upd = 6'b001000; e.tag = "R5";
        end else begin
          int p;
          int pc;
          p = (op == 3'd0) ? lo : hi;
          e.res = 16'(p); e.wr = 1'b1; e.upd = 6'b111111;
          pc = 0;
          for (int k = 0; k < 8; k++) pc += int'(e.res[k]);
          e.flg[1] = (pc % 2 == 0);
          e.flg[4] = e.res[15];
          e.tag = (op == 3'd0) ? "R2+R4" : "R3+R4";
        end
      end
      3'd2: begin
        e.res = 16'(ones); e.wr = 1'b1; e.upd = 6'b111111;
        e.flg[3] = (s == 16'd0); e.tag = "R6";
      end
      3'd3, 3'd4: begin
        if (s == 16'd0) e.res = 16'd16;
        else e.res = (op == 3'd3) ? 16'(lo) : 16'(15 - hi);
        e.wr = 1'b1; e.upd = 6'b001001;
        e.flg[0] = (s == 16'd0);
        e.flg[3] = (e.res == 16'd0);
        e.tag = (op == 3'd3) ? "R7+R9" : "R8+R9";
      end
      default: e.tag = "R10";
    endcase
    return e;
  endfunction

  task automatic issue(input logic [2:0] op, input logic [15:0] s);
    exp_q.push_back(model(op, s));
    valid_i = 1'b1;
    op_i    = op;
    src_i   = s;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check("R1 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " result"}, 32'(result_o), 32'(e.res));
          check({e.tag, " wr_en"}, 32'(wr_en_o), 32'(e.wr));
          check({e.tag, " upd"}, 32'(flag_upd_o), 32'(e.upd));
          if (e.upd != 6'd0) check({e.tag, " flags"}, 32'(flags_o & e.upd), 32'(e.flg & e.upd));
        end
      end else begin
        check("R11 idle quiet", {30'd0, wr_en_o, |flag_upd_o}, 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    valid_i = 1'b0; op_i = 3'd0; src_i = 16'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset done", 32'(done_o), 32'd0);
    check("R11 reset wr/upd", {30'd0, wr_en_o, |flag_upd_o}, 32'd0);
    rst_n = 1'b1;
    idle(4);

    // forward / reverse scans (R2 R3 R4 R5)
    issue(3'd0, 16'h0001); issue(3'd0, 16'h8000); issue(3'd0, 16'h0A00);
    issue(3'd0, 16'h0000); issue(3'd1, 16'h0001); issue(3'd1, 16'h8000);
    issue(3'd1, 16'h0A00); issue(3'd1, 16'h0000); issue(3'd0, 16'h0380);
    idle(2);
    // population count (R6)
    issue(3'd2, 16'h0000); issue(3'd2, 16'hFFFF); issue(3'd2, 16'h1234);
    idle(1);
    // trailing / leading zero counts (R7 R8 R9)
    issue(3'd3, 16'h0000); issue(3'd3, 16'h0001); issue(3'd3, 16'h8000);
    issue(3'd3, 16'h0100); issue(3'd4, 16'h0000); issue(3'd4, 16'h0001);
    issue(3'd4, 16'h8000); issue(3'd4, 16'hFFFF);
    idle(3);
    // unused codes (R10), mixed with real ones
    issue(3'd5, 16'h1234); issue(3'd0, 16'h0000); issue(3'd6, 16'hFFFF);
    issue(3'd2, 16'h00F0); issue(3'd7, 16'h0000);
    idle(2);
    // back-to-back stream (R1)
    lfsr = 16'hACE1;
    for (int n = 0; n < 60; n++) begin
      logic [15:0] s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = (n % 7 == 3) ? 16'h0000 : (lfsr & {lfsr[7:0], lfsr[15:8]});
      issue(3'(n % 8), s);
      if (n % 11 == 5) idle(1);
    end
    idle(4);
    check("R1 all answered", 32'(exp_q.size()), 32'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule